// File: doc/BRIEF.md
# Wide Decoder and Tristate Cell

A small supplemental logic cell that sits beside a logic cluster. Ten data inputs feed a configurable product-term stage: each input can be taken true or complemented, or dropped from the term altogether, and the stage either ANDs all of them into one wide decode or splits them into two five-input AND groups that are ORed, with an optional complement on the result. Typical uses are address decoding of any width from one to ten bits and short sum-of-products functions.

The same cell holds a bank of tristate buffers that put data onto an internal bidirectional bus. Each buffer carries one data input, optionally inverted, and is enabled either by its own enable pin or, for the whole bank at once, by the cell's own decode result. The decoded address then gates data onto the bus with no extra logic. A bus bit is modelled as a data bit plus a drive flag. An undriven bit presents data 0, so the outputs of several cells can be ORed onto one shared wire and contention found by counting drive flags.

All outputs are registered. A change on any input shows at the outputs on the first rising clock edge after it. The configuration inputs are treated as static words.

Top module: `wide_dec_tri_cell`

## Requirements
- R1: A synchronous active-high reset clears dec_out, every bus_drv bit and every bus_dat bit on the next rising edge.
- R2: With cfg_mode = 0 (wide AND), dec_out equals the AND of all ten literals, one clock after the inputs are applied.
- R3: The literal of input i is din[i] when cfg_inv_in[i] = 0 and ~din[i] when cfg_inv_in[i] = 1.
- R4: An input with cfg_use[i] = 0 contributes a constant 1 to its term, so the decode width is set by cfg_use; with cfg_use all zero in wide-AND mode dec_out is 1 for every din.
- R5: With cfg_mode = 1 (sum of products), dec_out is the OR of the AND of literals 0..4 and the AND of literals 5..9.
- R6: cfg_inv_out = 1 complements dec_out in sum-of-products mode and has no effect in wide-AND mode.
- R7: With cfg_en_src = 0, bus_drv[i] follows buf_en[i], and a bit with its drive flag low presents bus_dat[i] = 0 (high impedance).
- R8: A driven bus bit carries din[i] when cfg_buf_inv[i] = 0 and ~din[i] when cfg_buf_inv[i] = 1.
- R9: With cfg_en_src = 1, every bus_drv bit equals the decode result of the same cycle and buf_en has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cfg_mode | input | 1 | 0 = wide AND, 1 = two-group sum of products |
| cfg_inv_out | input | 1 | Complement the sum-of-products result |
| cfg_en_src | input | 1 | 0 = per-buffer enables, 1 = decode result enables all buffers |
| cfg_use | input | 10 | Per-input term membership; 0 forces the literal to 1 |
| cfg_inv_in | input | 10 | Per-input literal polarity; 1 = complemented |
| cfg_buf_inv | input | 10 | Per-buffer data polarity; 1 = inverted |
| din | input | 10 | Data inputs |
| buf_en | input | 10 | Per-buffer enable, active high |
| dec_out | output | 1 | Registered decode / sum-of-products result |
| bus_dat | output | 10 | Registered bus data, 0 when not driven |
| bus_drv | output | 10 | Registered bus drive flags |

## Verification
The decode holds no state beyond its output register. A wrong literal polarity, a wrong group boundary or a lost output complement therefore shows as a wrong dec_out one clock after the input pattern that exposes it. The sweep applies all 1024 din values under each configuration, so such a fault surfaces within one pass. A wrong enable source or a buffer that leaks data while undriven shows on bus_drv or bus_dat on the same edge. When the decode gates the bank, a decode fault also shows as all ten drive flags flipping together.

// File: rtl/wdec_pkg.sv
package wdec_pkg;
  typedef enum logic {
    MODE_AND = 1'b0,
    MODE_SOP = 1'b1
  } dec_mode_e;
endpackage

// File: rtl/wdec_literal.sv
module wdec_literal #(
  parameter int N_IN = 10
) (
  input  logic [N_IN-1:0] din,
  input  logic [N_IN-1:0] pol_inv,
  input  logic [N_IN-1:0] in_use,
  output logic [N_IN-1:0] lit
);
  for (genvar i = 0; i < N_IN; i++) begin : g_lit
    // unused inputs read as 1 so they drop out of the AND term
    assign lit[i] = in_use[i] ? (din[i] ^ pol_inv[i]) : 1'b1;
  end
endmodule

// File: rtl/wdec_core.sv
module wdec_core
  import wdec_pkg::*;
#(
  parameter int N_IN  = 10,
  parameter int N_GRP = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  dec_mode_e       mode,
  input  logic            inv_out,
  input  logic [N_IN-1:0] lit,
  output logic            dec_comb,
  output logic            dec_q
);
  localparam int GRP_W = N_IN / N_GRP;

  logic [N_GRP-1:0] grp_and;
  logic             wide_and;
  logic             sop;

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    assign grp_and[g] = &lit[g*GRP_W +: GRP_W];
  end

  assign wide_and = &lit;
  assign sop      = (|grp_and) ^ inv_out;

  always_comb begin
    if (mode == MODE_SOP) dec_comb = sop;
    else                  dec_comb = wide_and;
  end

  always_ff @(posedge clk) begin
    if (rst) dec_q <= 1'b0;
    else     dec_q <= dec_comb;
  end

  // R2: any false literal in wide-AND mode leaves the decode low
  p_and_zero_r2: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(mode == MODE_AND) && $past(lit != {N_IN{1'b1}})) |-> !dec_q)
    else $error("p_and_zero_r2");
endmodule

// File: rtl/wdec_bufbank.sv
module wdec_bufbank #(
  parameter int N_BUF = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_src,
  input  logic             dec_comb,
  input  logic [N_BUF-1:0] buf_en,
  input  logic [N_BUF-1:0] din,
  input  logic [N_BUF-1:0] dat_inv,
  output logic [N_BUF-1:0] bus_dat,
  output logic [N_BUF-1:0] bus_drv
);
  logic [N_BUF-1:0] drv_next;

  for (genvar i = 0; i < N_BUF; i++) begin : g_buf
    assign drv_next[i] = en_src ? dec_comb : buf_en[i];

    always_ff @(posedge clk) begin
      if (rst) begin
        bus_drv[i] <= 1'b0;
        bus_dat[i] <= 1'b0;
      end else begin
        bus_drv[i] <= drv_next[i];
        bus_dat[i] <= drv_next[i] & (din[i] ^ dat_inv[i]);
      end
    end

    // R7: an undriven bit presents no data
    p_hiz_quiet_r7: assert property (@(posedge clk) disable iff (rst)
      !bus_drv[i] |-> !bus_dat[i])
      else $error("p_hiz_quiet_r7");
  end
endmodule

// File: rtl/wide_dec_tri_cell.sv
module wide_dec_tri_cell
  import wdec_pkg::*;
#(
  parameter int N_IN  = 10,
  parameter int N_GRP = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_mode,
  input  logic            cfg_inv_out,
  input  logic            cfg_en_src,
  input  logic [N_IN-1:0] cfg_use,
  input  logic [N_IN-1:0] cfg_inv_in,
  input  logic [N_IN-1:0] cfg_buf_inv,
  input  logic [N_IN-1:0] din,
  input  logic [N_IN-1:0] buf_en,
  output logic            dec_out,
  output logic [N_IN-1:0] bus_dat,
  output logic [N_IN-1:0] bus_drv
);
  logic [N_IN-1:0] lit;
  logic            dec_comb;
  dec_mode_e       mode;

  assign mode = dec_mode_e'(cfg_mode);

  wdec_literal #(.N_IN(N_IN)) lit_i (
    .din     (din),
    .pol_inv (cfg_inv_in),
    .in_use  (cfg_use),
    .lit     (lit)
  );

  wdec_core #(.N_IN(N_IN), .N_GRP(N_GRP)) core_i (
    .clk      (clk),
    .rst      (rst),
    .mode     (mode),
    .inv_out  (cfg_inv_out),
    .lit      (lit),
    .dec_comb (dec_comb),
    .dec_q    (dec_out)
  );

  wdec_bufbank #(.N_BUF(N_IN)) bank_i (
    .clk      (clk),
    .rst      (rst),
    .en_src   (cfg_en_src),
    .dec_comb (dec_comb),
    .buf_en   (buf_en),
    .din      (din),
    .dat_inv  (cfg_buf_inv),
    .bus_dat  (bus_dat),
    .bus_drv  (bus_drv)
  );

  // R9: decode-gated bank drives all bits together with the decode
  p_gate_follow_r9: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(cfg_en_src)) |-> (bus_drv == {N_IN{dec_out}}))
    else $error("p_gate_follow_r9");

  // R4: an empty wide-AND term always decodes true
  p_empty_and_r4: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(cfg_use == '0) && $past(cfg_mode == 1'b0)) |-> dec_out)
    else $error("p_empty_and_r4");

  // R6: empty sum-of-products term gives 1, complemented by the output invert
  p_sop_inv_r6: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(cfg_use == '0) && $past(cfg_mode == 1'b1))
      |-> (dec_out == !$past(cfg_inv_out)))
    else $error("p_sop_inv_r6");
endmodule

// File: tb/wide_dec_tri_cell_tb.sv
module wide_dec_tri_cell_tb_top;
  localparam int CLK_P = 10;
  localparam int N = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_mode = 1'b0, cfg_inv_out = 1'b0, cfg_en_src = 1'b0;
  logic [N-1:0] cfg_use = '1, cfg_inv_in = '0, cfg_buf_inv = '0;
  logic [N-1:0] din = '0, buf_en = '0;
  logic dec_out;
  logic [N-1:0] bus_dat, bus_drv;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_P/2) clk = ~clk;

  wide_dec_tri_cell dut_i (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_inv_out(cfg_inv_out),
    .cfg_en_src(cfg_en_src), .cfg_use(cfg_use), .cfg_inv_in(cfg_inv_in),
    .cfg_buf_inv(cfg_buf_inv), .din(din), .buf_en(buf_en),
    .dec_out(dec_out), .bus_dat(bus_dat), .bus_drv(bus_drv)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h (din=%h)", req, act, exp, din);
    end
  endtask

  // expected decode computed as counts of satisfied literals
  function automatic logic model_dec(logic [N-1:0] d);
    int hit_lo = 0, hit_hi = 0;
    for (int i = 0; i < N; i++) begin
      logic v;
      v = (cfg_use[i] == 1'b0) || (d[i] != cfg_inv_in[i]);
      if (v) begin
        if (i < N/2) hit_lo++;
        else         hit_hi++;
      end
    end
    if (cfg_mode == 1'b0) return (hit_lo + hit_hi) == N;
    return ((hit_lo == N/2) || (hit_hi == N/2)) != cfg_inv_out;
  endfunction

  task automatic sweep(input string rd, input string rb);
    for (int v = 0; v < 1024; v++) begin
      logic e_dec;
      logic [N-1:0] e_drv, e_dat;
      @(negedge clk);
      din    = v[N-1:0];
      buf_en = v[N-1:0] ^ {v[4:0], v[9:5]} ^ 10'h2A5;
      e_dec  = model_dec(din);
      e_drv  = cfg_en_src ? {N{e_dec}} : buf_en;
      e_dat  = e_drv & (din ^ cfg_buf_inv);
      @(posedge clk);
      #1;
      chk(rd, {31'd0, dec_out}, {31'd0, e_dec});
      chk(rb, {22'd0, bus_drv, bus_dat}, {22'd0, e_drv, e_dat});
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    din = '1; buf_en = '1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 dec", {31'd0, dec_out}, 32'd0);
    chk("R1 bus", {22'd0, bus_drv, bus_dat}, 32'd0);
    @(negedge clk); rst = 1'b0;

    // R2: full-width AND, true literals, per-buffer enables (R7)
    sweep("R2", "R7");
    // R3: mixed polarity literals; R8 inverted buffer data
    cfg_inv_in = 10'h155; cfg_buf_inv = 10'h3C3;
    sweep("R3", "R8");
    // R4: partial width decode
    cfg_use = 10'h0F3; cfg_inv_in = 10'h0A1;
    sweep("R4", "R8");
    // R4: empty term; R6 output invert ignored in wide-AND mode
    cfg_use = '0; cfg_inv_out = 1'b1;
    sweep("R6", "R7");
    // R5: two-group sum of products
    cfg_mode = 1'b1; cfg_inv_out = 1'b0; cfg_use = '1; cfg_inv_in = 10'h2D4;
    sweep("R5", "R7");
    // R6: complemented sum of products with a partly empty group
    cfg_inv_out = 1'b1; cfg_use = 10'h3E7;
    sweep("R6", "R8");
    // R9: decode gates the whole bank, buf_en ignored
    cfg_en_src = 1'b1; cfg_inv_out = 1'b0; cfg_use = '1;
    sweep("R5", "R9");
    cfg_mode = 1'b0; cfg_inv_in = 10'h3F0; cfg_buf_inv = '0;
    sweep("R2", "R9");

    // R1: reset mid-run clears outputs
    @(negedge clk); rst = 1'b1; din = 10'h00F; buf_en = '1;
    @(posedge clk); #1;
    chk("R1 dec", {31'd0, dec_out}, 32'd0);
    chk("R1 bus", {22'd0, bus_drv, bus_dat}, 32'd0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule